// File: doc/BRIEF.md
# Block-Throttled Inbound Pipe Receive Buffer

This block sits behind a host-driven inbound data pipe that moves 32-bit words in fixed-size blocks. The host is the master. It pulses a block strobe for one cycle before each block. It then writes the words of that block on any clock edge at which the write strobe is high, and it may leave idle gaps between words. The buffer tells the host through a ready output when a whole block of space is free. It accepts every word into a synchronous FIFO, and user logic drains the FIFO through a valid/ready read port.

Free space is counted in whole blocks. The count covers the words already stored and also the words still owed by the block in flight. A new block strobe therefore reserves a block of space at once, and the same space is never offered twice. Two sticky error flags report host misbehaviour. One flags a word that arrives while the FIFO is full. The other flags a block that does not carry exactly one block's worth of words.

Top module: `blkpipe_rx_buf`

## Requirements
- R1: After synchronous reset, `in_ready` is high, `out_valid` is low, and `ovf_err` and `proto_err` are low.
- R2: Every word presented with `in_wr` high at a rising edge, while the FIFO is not full, is stored. Stored words leave on `out_data` in arrival order, whatever idle gaps separate them on the write side.
- R3: `in_ready` is high exactly when the stored word count plus the words still owed by the open block is at most DEPTH minus BLOCK_WORDS (DEPTH = BLOCK_WORDS × DEPTH_BLOCKS).
- R4: A block strobe reserves BLOCK_WORDS of space from the next cycle. `in_ready` therefore stays high after a strobe only if at least two blocks of space were free before the strobe.
- R5: A write at an edge where the FIFO holds DEPTH words is dropped, and `ovf_err` is set and stays set until reset.
- R6: A block strobe that arrives before the previous block has delivered all BLOCK_WORDS words sets `proto_err`, which stays set until reset. A write in the same cycle as the strobe counts toward the previous block.
- R7: A write while no block is open (no words owed) sets `proto_err`.
- R8: `out_valid` is high exactly when the FIFO holds at least one word. `out_data` shows the oldest word, and that word is removed at an edge where `out_valid` and `out_ready` are both high.
- R9: A write and a read at the same edge leave the stored word count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 32 | Inbound word from the host |
| in_wr | input | 1 | Inbound word valid at this edge |
| in_blkstb | input | 1 | One-cycle pulse ahead of a block |
| in_ready | output | 1 | A full block of space is available |
| out_data | output | 32 | Oldest stored word |
| out_valid | output | 1 | FIFO not empty |
| out_ready | input | 1 | Consumer takes the word at this edge |
| ovf_err | output | 1 | Sticky: word arrived while full |
| proto_err | output | 1 | Sticky: block word count mismatch |

## Verification
The hardest state to reach is the boundary where a strobe arrives with exactly two blocks, or only one block, of uncommitted space. That case depends on how reads and gapped writes have interleaved in earlier blocks. The bench sweeps every pattern of idle gaps inside a four-word block against several read cadences on a small configuration. At each edge it compares ready against an arithmetic model of stored plus owed words. It then deliberately fills the buffer and breaks the protocol to drive the full and mismatch corners.

// File: rtl/blkpipe_pkg.sv
package blkpipe_pkg;

    localparam int PIPE_W = 32;

    typedef struct packed {
        logic              wr;
        logic              stb;
        logic [PIPE_W-1:0] data;
    } pipe_beat_t;

    typedef enum logic [1:0] {
        BC_OK    = 2'd0,
        BC_SHORT = 2'd1,
        BC_STRAY = 2'd2
    } blk_check_t;

    function automatic logic [1:0] err_code(input logic stray, input logic short_blk);
        if (stray)          return BC_STRAY;
        else if (short_blk) return BC_SHORT;
        else                return BC_OK;
    endfunction

endpackage

// File: rtl/blkpipe_fifo.sv
module blkpipe_fifo #(
    parameter int DEPTH = 1024,
    parameter int W     = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic [W-1:0]     push_data,
    input  logic             pop_req,
    output logic [W-1:0]     head_data,
    output logic [CNT_W-1:0] level,
    output logic             ovf
);
    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             is_full, is_empty, push_ok, pop_ok;

    assign is_full  = (level == CNT_W'(DEPTH));
    assign is_empty = (level == '0);
    assign push_ok  = push_req && !is_full;
    assign pop_ok   = pop_req && !is_empty;
    assign head_data = store[rptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) store[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push_ok) wptr <= nxt(wptr);
            if (pop_ok)  rptr <= nxt(rptr);
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
            if (push_req && is_full) ovf <= 1'b1;
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        level <= CNT_W'(DEPTH));
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    assert_balanced_R9: assert property (@(posedge clk) disable iff (rst)
        (push_ok && pop_ok) |=> level == $past(level));
    assert_pop_step_R8: assert property (@(posedge clk) disable iff (rst)
        (pop_ok && !push_req) |=> level == $past(level) - 1'b1);

endmodule

// File: rtl/blkpipe_blkcount.sv
module blkpipe_blkcount
    import blkpipe_pkg::*;
#(
    parameter int BLOCK_WORDS = 256,
    localparam int PEND_W = $clog2(BLOCK_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              stb,
    output logic [PEND_W-1:0] owed,
    output logic              proto
);
    logic       in_block, wr_in_block, stray, short_blk;
    logic [1:0] code;

    assign in_block    = (owed != '0);
    assign wr_in_block = wr && in_block;
    assign stray       = wr && !in_block;
    assign short_blk   = stb && ((owed - PEND_W'(wr_in_block)) != '0);
    assign code        = err_code(stray, short_blk);

    always_ff @(posedge clk) begin
        if (rst) begin
            owed  <= '0;
            proto <= 1'b0;
        end else begin
            if (stb)              owed <= PEND_W'(BLOCK_WORDS);
            else if (wr_in_block) owed <= owed - 1'b1;
            if (code != BC_OK)    proto <= 1'b1;
        end
    end

    assert_owed_bound_R3: assert property (@(posedge clk) disable iff (rst)
        owed <= PEND_W'(BLOCK_WORDS));
    assert_proto_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        proto |=> proto);
    assert_stray_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (wr && owed == '0) |=> proto);

endmodule

// File: rtl/blkpipe_credit.sv
module blkpipe_credit #(
    parameter int BLOCK_WORDS = 256,
    parameter int DEPTH       = 1024,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PEND_W = $clog2(BLOCK_WORDS + 1),
    localparam int SUM_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  level,
    input  logic [PEND_W-1:0] owed,
    output logic              ready
);
    logic [SUM_W-1:0] committed;

    assign committed = SUM_W'(level) + SUM_W'(owed);
    assign ready     = committed <= SUM_W'(DEPTH - BLOCK_WORDS);

    assert_ready_room_R3: assert property (@(posedge clk) disable iff (rst)
        ready |-> level <= CNT_W'(DEPTH - BLOCK_WORDS));

endmodule

// File: rtl/blkpipe_rx_buf.sv
module blkpipe_rx_buf
    import blkpipe_pkg::*;
#(
    parameter int BLOCK_WORDS  = 256,
    parameter int DEPTH_BLOCKS = 4,
    localparam int DEPTH  = BLOCK_WORDS * DEPTH_BLOCKS,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PEND_W = $clog2(BLOCK_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIPE_W-1:0] in_data,
    input  logic              in_wr,
    input  logic              in_blkstb,
    output logic              in_ready,
    output logic [PIPE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              ovf_err,
    output logic              proto_err
);
    pipe_beat_t        beat;
    logic [CNT_W-1:0]  level;
    logic [PEND_W-1:0] owed;

    assign beat = '{wr: in_wr, stb: in_blkstb, data: in_data};
    assign out_valid = (level != '0);

    blkpipe_fifo #(.DEPTH(DEPTH), .W(PIPE_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push_req(beat.wr), .push_data(beat.data),
        .pop_req(out_valid && out_ready),
        .head_data(out_data), .level(level), .ovf(ovf_err)
    );

    blkpipe_blkcount #(.BLOCK_WORDS(BLOCK_WORDS)) u_count (
        .clk(clk), .rst(rst),
        .wr(beat.wr), .stb(beat.stb),
        .owed(owed), .proto(proto_err)
    );

    blkpipe_credit #(.BLOCK_WORDS(BLOCK_WORDS), .DEPTH(DEPTH)) u_credit (
        .clk(clk), .rst(rst),
        .level(level), .owed(owed), .ready(in_ready)
    );

    assert_strobe_reserve_R4: assert property (@(posedge clk) disable iff (rst)
        (in_blkstb && !in_wr && level >= CNT_W'(DEPTH - 2 * BLOCK_WORDS + 1) && !out_ready)
        |=> !in_ready);

endmodule

// File: tb/tb_blkpipe_rx_buf.sv
module tb_blkpipe_rx_buf;
    localparam int BW = 4;
    localparam int NB = 3;
    localparam int DP = BW * NB;

    logic        clk = 0, rst = 1;
    logic [31:0] in_data = 0;
    logic        in_wr = 0, in_blkstb = 0, out_ready = 0;
    logic        in_ready, out_valid, ovf_err, proto_err;
    logic [31:0] out_data;

    blkpipe_rx_buf #(.BLOCK_WORDS(BW), .DEPTH_BLOCKS(NB)) dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_wr(in_wr),
        .in_blkstb(in_blkstb), .in_ready(in_ready), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .ovf_err(ovf_err), .proto_err(proto_err)
    );

    always #5 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    logic [31:0] q[$];
    int  m_owed = 0;
    bit  m_ovf = 0, m_proto = 0, last_stb = 0;
    logic [31:0] seq = 32'h1000;
    string ptag = "R6";

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; in_wr = 0; in_blkstb = 0; out_ready = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rst = 0;
        q.delete(); m_owed = 0; m_ovf = 0; m_proto = 0; last_stb = 0;
        chk(in_ready == 1, "R1 ready", 32'(in_ready), 1);
        chk(out_valid == 0, "R1 valid", 32'(out_valid), 0);
        chk(ovf_err == 0 && proto_err == 0, "R1 errors", {ovf_err, proto_err}, 0);
    endtask

    task automatic step(input bit wr, input bit stb, input bit rd);
        bit wok;
        @(negedge clk);
        in_wr = wr; in_blkstb = stb; out_ready = rd;
        if (wr) begin in_data = seq; seq = seq + 32'h11; end
        #1;
        if (rd && q.size() > 0)
            chk(out_data == q[0], wr ? "R9 data" : "R2 data", out_data, q[0]);
        // model the edge
        wok = wr && (m_owed != 0);
        if (wr && m_owed == 0) m_proto = 1;
        if (stb && (m_owed - int'(wok)) != 0) m_proto = 1;
        m_owed = stb ? BW : m_owed - int'(wok);
        if (rd && q.size() > 0) void'(q.pop_front());
        if (wr) begin
            if (q.size() + (rd ? 0 : 0) >= DP && !(0)) m_ovf = 1;
            else q.push_back(in_data);
        end
        @(posedge clk); #1;
        cyc++;
        chk(in_ready == ((q.size() + m_owed) <= DP - BW), last_stb ? "R3" : (stb ? "R4 ready" : "R3 ready"),
            32'(in_ready), 32'((q.size() + m_owed) <= DP - BW));
        chk(out_valid == (q.size() > 0), "R8 valid", 32'(out_valid), 32'(q.size() > 0));
        chk(ovf_err == m_ovf, "R5 ovf", 32'(ovf_err), 32'(m_ovf));
        chk(proto_err == m_proto, ptag, 32'(proto_err), 32'(m_proto));
        last_stb = 0;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // sweep of gap patterns within a block against read cadences (R2, R3, R4, R8, R9)
        for (int g = 0; g < 16; g++) begin
            for (int r = 0; r < 4; r++) begin
                while (!in_ready) step(0, 0, 1);
                step(0, 1, (r == 1) || (r == 2 && cyc[0]) || (r == 3 && cyc[1]));
                for (int w = 0; w < BW; w++) begin
                    bit rb;
                    rb = (r == 1) || (r == 2 && cyc[0]) || (r == 3 && cyc[1]);
                    if (g[w]) step(0, 0, rb);
                    step(1, 0, rb);
                end
            end
        end
        while (out_valid) step(0, 0, 1);
        // fill to the reservation limit: third strobe must drop ready (R4)
        for (int b = 0; b < NB; b++) begin
            step(0, 1, 0);
            chk(in_ready == (b < NB - 1), "R4 strobe reserve", 32'(in_ready), 32'(b < NB - 1));
            for (int w = 0; w < BW; w++) step(1, 0, 0);
        end
        // write into a full buffer with no block open (R5, R7)
        ptag = "R7";
        step(1, 0, 0);
        chk(ovf_err == 1, "R5 overflow set", 32'(ovf_err), 1);
        step(0, 0, 0);
        chk(ovf_err == 1, "R5 overflow sticky", 32'(ovf_err), 1);
        chk(proto_err == 1, "R7 stray word", 32'(proto_err), 1);
        for (int i = 0; i < DP; i++) step(0, 0, 1);
        chk(out_valid == 0, "R5 dropped word absent", 32'(out_valid), 0);
        // short block (R6)
        ptag = "R6";
        do_reset();
        step(0, 1, 0); step(1, 0, 0); step(1, 0, 0);
        chk(proto_err == 0, "R6 before second strobe", 32'(proto_err), 0);
        step(1, 1, 0);
        chk(proto_err == 1, "R6 short block", 32'(proto_err), 1);
        for (int w = 0; w < BW; w++) step(1, 0, 1);
        chk(proto_err == 1, "R6 sticky", 32'(proto_err), 1);
        // exact block with write in strobe cycle counts to old block (R6)
        do_reset();
        step(0, 1, 0); step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
        step(1, 1, 0);
        chk(proto_err == 0, "R6 write with strobe closes block", 32'(proto_err), 0);
        // stray word after reset (R7)
        ptag = "R7";
        do_reset();
        step(1, 0, 1);
        chk(proto_err == 1, "R7 word outside block", 32'(proto_err), 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule